// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a two-part logical address into a physical address. The two parts are a segment number and an offset inside that segment. A small on-chip table holds one descriptor per segment. Each descriptor has a physical base, a length, a present flag and three access-right flags (read, write, execute). A length register sets how many segment numbers the current program may use.

Each request checks four things, in this order:
1. the segment number against the length register;
2. the present flag;
3. the offset against the segment length;
4. the requested access kind against the rights.

A request that passes every check returns base plus offset. Any other request returns a fault code and a zero address. The response is registered and appears one cycle after the request.

A configuration port loads one descriptor or the length register per cycle. The new value is visible to requests from the next cycle on.

Top module: `segxlat_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `rsp_valid` is 0. Reset clears the length register to 0 and marks every descriptor not present, so any request made right after reset gets fault code 2'b01.
- R2: A response appears exactly one cycle after `req_valid` is sampled high. In any cycle where `rsp_valid` is 0, `rsp_fault` and `rsp_paddr` are both 0.
- R3: If the segment number is greater than or equal to the length register, the fault code is 2'b01. This check wins over every other check.
- R4: A legal segment whose descriptor has its present flag at 0 gives fault code 2'b10.
- R5: An offset greater than or equal to the segment length gives fault code 2'b10. An offset of length minus 1 is accepted. This check wins over the rights check.
- R6: The access kind is encoded on `req_acc` as 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. The rights are encoded on `cfg_perm` as bit 0 read, bit 1 write, bit 2 execute. An access whose right bit is clear gives fault 2'b11. The reserved kind always gives fault 2'b11.
- R7: A request that passes every check gives fault 2'b00 and address base plus offset, taken modulo 2^PA_W.
- R8: A configuration write with `cfg_sel`=0 loads the descriptor selected by `cfg_idx`. A write with `cfg_sel`=1 loads the length register. A request in the same cycle as a write still sees the old contents; a request in the next cycle sees the new ones.
- R9: Every faulting response carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes a descriptor, 1 writes the length register |
| cfg_idx | input | SEG_W | Descriptor index |
| cfg_base | input | PA_W | Physical base of the segment |
| cfg_limit | input | OFF_W+1 | Segment length in address units |
| cfg_present | input | 1 | Present flag |
| cfg_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cfg_len | input | SEG_W+1 | Number of legal segment numbers |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset inside the segment |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_fault | output | 2 | Fault code (00 none, 01 range, 10 absent/bounds, 11 rights) |

## Verification
The properties assume two things about the inputs:
- reset is held low for at least one clock edge;
- request and configuration inputs are stable around each rising edge.

The properties make no assumption about overlap between a configuration write and a request. The stimulus keeps to these assumptions:
- it changes every input only on the falling clock edge;
- it holds reset low over several edges;
- it deliberately overlaps writes with requests to exercise the old-contents rule.

// File: rtl/segx_pkg.sv
// Package: shared encodings for the segmented translation unit.
// Assumes: every user imports it rather than redefining the codes.
package segx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_RANGE = 2'b01,
        FLT_BOUND = 2'b10,
        FLT_PERM  = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } access_e;

    localparam int PERM_W  = 3;
    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;
endpackage

// File: rtl/segx_table.sv
// Module: descriptor storage and length register.
// Holds SEG_COUNT descriptors and offers one asynchronous read port.
// Assumes: SEG_COUNT is a power of two, so every index addresses an entry.
module segx_table #(
    parameter int SEG_COUNT = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_len_sel,
    input  logic [SEG_W-1:0]          wr_idx,
    input  logic [PA_W-1:0]           wr_base,
    input  logic [OFF_W:0]            wr_limit,
    input  logic                      wr_present,
    input  logic [segx_pkg::PERM_W-1:0] wr_perm,
    input  logic [SEG_W:0]            wr_len,
    input  logic [SEG_W-1:0]          rd_idx,
    output logic [PA_W-1:0]           rd_base,
    output logic [OFF_W:0]            rd_limit,
    output logic                      rd_present,
    output logic [segx_pkg::PERM_W-1:0] rd_perm,
    output logic [SEG_W:0]            len_q
);
    logic [PA_W-1:0]             base_q    [SEG_COUNT];
    logic [OFF_W:0]              limit_q   [SEG_COUNT];
    logic                        present_q [SEG_COUNT];
    logic [segx_pkg::PERM_W-1:0] perm_q    [SEG_COUNT];

    // Length register: cleared by reset, loaded by a length write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (wr_en && wr_len_sel)
            len_q <= wr_len;
    end

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        // Per-descriptor registers: reset marks the entry absent.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]    <= '0;
                limit_q[g]   <= '0;
                present_q[g] <= 1'b0;
                perm_q[g]    <= '0;
            end else if (wr_en && !wr_len_sel && (wr_idx == SEG_W'(g))) begin
                base_q[g]    <= wr_base;
                limit_q[g]   <= wr_limit;
                present_q[g] <= wr_present;
                perm_q[g]    <= wr_perm;
            end
        end
    end

    // Read port: selects the descriptor addressed by the request.
    always_comb begin
        rd_base    = base_q[rd_idx];
        rd_limit   = limit_q[rd_idx];
        rd_present = present_q[rd_idx];
        rd_perm    = perm_q[rd_idx];
    end
endmodule

// File: rtl/segx_check.sv
// Module: combinational legality checks and address formation.
// Check order: range, present, bounds, rights.
// Assumes: OFF_W <= PA_W; the sum wraps modulo 2^PA_W.
module segx_check #(
    parameter int SEG_COUNT = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic [SEG_W-1:0]            seg,
    input  logic [OFF_W-1:0]            off,
    input  segx_pkg::access_e           acc,
    input  logic [SEG_W:0]              len,
    input  logic [PA_W-1:0]             base,
    input  logic [OFF_W:0]              limit,
    input  logic                        present,
    input  logic [segx_pkg::PERM_W-1:0] perm,
    output segx_pkg::fault_e            fault,
    output logic [PA_W-1:0]             paddr
);
    import segx_pkg::*;

    logic right_ok;

    // Rights decode: pick the right bit that matches the access kind.
    always_comb begin
        case (acc)
            ACC_READ:  right_ok = perm[RIGHT_R];
            ACC_WRITE: right_ok = perm[RIGHT_W];
            ACC_EXEC:  right_ok = perm[RIGHT_X];
            default:   right_ok = 1'b0;
        endcase
    end

    // Priority chain: the first failing check decides the code.
    always_comb begin
        if ({1'b0, seg} >= len)
            fault = FLT_RANGE;
        else if (!present)
            fault = FLT_BOUND;
        else if ({1'b0, off} >= limit)
            fault = FLT_BOUND;
        else if (!right_ok)
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
    end

    // Address formation: zero unless the access is legal.
    always_comb begin
        if (fault == FLT_NONE)
            paddr = base + PA_W'(off);
        else
            paddr = '0;
    end
endmodule

// File: rtl/segxlat_unit.sv
// Module: top of the segmented address translation unit.
// Registers one translation per cycle, one cycle after the request.
// Assumes: synchronous active-low reset held for at least one edge.
module segxlat_unit #(
    parameter int SEG_COUNT = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [SEG_W-1:0]   cfg_idx,
    input  logic [PA_W-1:0]    cfg_base,
    input  logic [OFF_W:0]     cfg_limit,
    input  logic               cfg_present,
    input  logic [2:0]         cfg_perm,
    input  logic [SEG_W:0]     cfg_len,
    input  logic               req_valid,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault
);
    import segx_pkg::*;

    logic [PA_W-1:0]  ent_base;
    logic [OFF_W:0]   ent_limit;
    logic             ent_present;
    logic [2:0]       ent_perm;
    logic [SEG_W:0]   len_q;
    fault_e           chk_fault;
    logic [PA_W-1:0]  chk_paddr;

    segx_table #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_len_sel (cfg_sel),
        .wr_idx     (cfg_idx),
        .wr_base    (cfg_base),
        .wr_limit   (cfg_limit),
        .wr_present (cfg_present),
        .wr_perm    (cfg_perm),
        .wr_len     (cfg_len),
        .rd_idx     (req_seg),
        .rd_base    (ent_base),
        .rd_limit   (ent_limit),
        .rd_present (ent_present),
        .rd_perm    (ent_perm),
        .len_q      (len_q)
    );

    segx_check #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) check_i (
        .seg     (req_seg),
        .off     (req_off),
        .acc     (access_e'(req_acc)),
        .len     (len_q),
        .base    (ent_base),
        .limit   (ent_limit),
        .present (ent_present),
        .perm    (ent_perm),
        .fault   (chk_fault),
        .paddr   (chk_paddr)
    );

    // Response stage: capture the result, or drive zeros when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= req_valid ? chk_paddr : '0;
            rsp_fault <= req_valid ? chk_fault : FLT_NONE;
        end
    end
endmodule

// File: rtl/segx_chk.sv
// Module: property checker bound into segxlat_unit.
// Assumes: inputs are stable around rising edges.
module segx_chk #(
    parameter int SEG_W = 4,
    parameter int PA_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_sel,
    input logic [SEG_W:0]   cfg_len,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   len_q,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 2'b00 && rsp_paddr == '0));
    // R3
    range_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_fault == 2'b01));
    // R8
    len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (len_q == $past(cfg_len)));
    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));
endmodule

bind segxlat_unit segx_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_len   (cfg_len),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .len_q     (len_q),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/segxlat_unit_tb.sv
// Bench: vector table walk, then directed reset and overlap cases.
module segxlat_unit_tb_top;
    localparam int SEG_COUNT = 16;
    localparam int OFF_W     = 16;
    localparam int PA_W      = 24;
    localparam int SEG_W     = 4;
    localparam int NVEC      = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W:0]   cfg_limit = '0;
    logic             cfg_present = 1'b0;
    logic [2:0]       cfg_perm = '0;
    logic [SEG_W:0]   cfg_len = '0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic [1:0]       rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    segxlat_unit #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (.*);

    // Vector fields: seg, off, acc, expected fault, expected address.
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd0,  16'h0000, 2'd0, 2'd0, 24'h100000},  // R7
        {4'd0,  16'h0FFF, 2'd2, 2'd0, 24'h100FFF},  // R5 R7
        {4'd0,  16'h1000, 2'd0, 2'd2, 24'h000000},  // R5 R9
        {4'd1,  16'h01FF, 2'd0, 2'd0, 24'h0000FF},  // R7 wrap
        {4'd1,  16'h0010, 2'd1, 2'd3, 24'h000000},  // R6
        {4'd1,  16'h0010, 2'd2, 2'd3, 24'h000000},  // R6
        {4'd1,  16'h0200, 2'd1, 2'd2, 24'h000000},  // R5 over R6
        {4'd2,  16'hFFFF, 2'd1, 2'd0, 24'h011FFF},  // R7
        {4'd2,  16'h0000, 2'd0, 2'd3, 24'h000000},  // R6
        {4'd3,  16'h0000, 2'd0, 2'd2, 24'h000000},  // R4
        {4'd3,  16'h0200, 2'd1, 2'd2, 24'h000000},  // R4
        {4'd4,  16'h0000, 2'd0, 2'd3, 24'h000000},  // R6
        {4'd0,  16'h0004, 2'd3, 2'd3, 24'h000000},  // R6 reserved
        {4'd5,  16'h0000, 2'd0, 2'd1, 24'h000000},  // R3
        {4'd15, 16'h0000, 2'd0, 2'd1, 24'h000000}   // R3
    };

    // Compare one value and report a failure line.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive inputs at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic we, input logic sel, input logic [SEG_W-1:0] idx,
                        input logic [PA_W-1:0] base, input logic [OFF_W:0] lim,
                        input logic pres, input logic [2:0] perm, input logic [SEG_W:0] len,
                        input logic rv, input logic [SEG_W-1:0] seg,
                        input logic [OFF_W-1:0] off, input logic [1:0] acc);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_base = base;
        cfg_limit = lim; cfg_present = pres; cfg_perm = perm; cfg_len = len;
        req_valid = rv; req_seg = seg; req_off = off; req_acc = acc;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic put_entry(input logic [SEG_W-1:0] idx, input logic [PA_W-1:0] base,
                             input logic [OFF_W:0] lim, input logic pres, input logic [2:0] perm);
        step(1'b1, 1'b0, idx, base, lim, pres, perm, '0, 1'b0, '0, '0, 2'd0);
    endtask

    task automatic ask(input logic [SEG_W-1:0] seg, input logic [OFF_W-1:0] off, input logic [1:0] acc);
        step(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b1, seg, off, acc);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0, '0, 2'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: outputs low during reset
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 valid after reset", 32'(rsp_valid), 32'd0);
        ask(4'd0, 16'h0000, 2'd0);
        check("R1 fault after reset", 32'(rsp_fault), 32'd1);

        // Load descriptors and the length register.
        put_entry(4'd0, 24'h100000, 17'h01000, 1'b1, 3'b111);
        put_entry(4'd1, 24'hFFFF00, 17'h00200, 1'b1, 3'b001);
        put_entry(4'd2, 24'h002000, 17'h10000, 1'b1, 3'b110);
        put_entry(4'd3, 24'h300000, 17'h00100, 1'b0, 3'b111);
        put_entry(4'd4, 24'h400000, 17'h00100, 1'b1, 3'b000);
        put_entry(4'd5, 24'h005000, 17'h00100, 1'b1, 3'b111);
        step(1'b1, 1'b1, '0, '0, '0, 1'b0, '0, 5'd5, 1'b0, '0, '0, 2'd0);

        for (int i = 0; i < NVEC; i++) begin
            ask(VEC[i][47:44], VEC[i][43:28], VEC[i][27:26]);
            check($sformatf("R2 valid vec%0d", i), 32'(rsp_valid), 32'd1);
            check($sformatf("R3-R7 fault vec%0d", i), 32'(rsp_fault), 32'(VEC[i][25:24]));
            check($sformatf("R7 R9 addr vec%0d", i), 32'(rsp_paddr), 32'(VEC[i][23:0]));
        end

        // R2: no request gives an idle, zeroed response
        idle();
        check("R2 idle valid", 32'(rsp_valid), 32'd0);
        check("R2 idle fault", 32'(rsp_fault), 32'd0);
        check("R2 idle addr", 32'(rsp_paddr), 32'd0);

        // R8: a request in the same cycle as a descriptor write sees the old descriptor
        step(1'b1, 1'b0, 4'd3, 24'h300000, 17'h00100, 1'b1, 3'b111, '0, 1'b1, 4'd3, 16'h0010, 2'd0);
        check("R8 same-cycle entry", 32'(rsp_fault), 32'd2);
        ask(4'd3, 16'h0010, 2'd0);
        check("R8 next-cycle entry fault", 32'(rsp_fault), 32'd0);
        check("R8 next-cycle entry addr", 32'(rsp_paddr), 32'h300010);

        // R8: the same rule applies to a length write
        step(1'b1, 1'b1, '0, '0, '0, 1'b0, '0, 5'd6, 1'b1, 4'd5, 16'h0004, 2'd0);
        check("R8 same-cycle len", 32'(rsp_fault), 32'd1);
        ask(4'd5, 16'h0004, 2'd0);
        check("R8 next-cycle len", 32'(rsp_paddr), 32'h005004);

        // R1: a mid-run reset clears the table and the length register
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 valid mid reset", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ask(4'd0, 16'h0000, 2'd0);
        check("R1 fault after re-reset", 32'(rsp_fault), 32'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule